// File: doc/BRIEF.md
# Banked Register File with Dual Stack Pointers

This block holds the general registers of a small 16-bit controller core. Eight word registers are visible at any time. The lower four are replicated in four banks, and a 2-bit bank input picks the live copy. Registers four to six are common to every bank. The topmost register is the stack pointer. It aliases one of two physical pointers, user or supervisor, chosen by a mode input.

Every register can be reached in three sizes: as a whole word, as either byte half, or as a single bit. There is one synchronous write port and two combinational read ports. Push and pop strobes step the live stack pointer by two. They present the memory address the stack access should use, and that memory lies outside this block.

Top module: `banked_regfile`

## Requirements
- R1: After reset every general register copy reads 0x0000 and both stack pointers read 0x0100; with no stack strobe, `stk_addr` equals the live stack pointer.
- R2: Registers 0–3 exist once per bank; `bank_sel` picks the copy for both reads and writes from the next access on, and a bank switch copies nothing.
- R3: Registers 4–6 are one storage each, seen identically from all four banks.
- R4: Size code 1 is a byte access: `sel[3:0]` is the byte location, register = `sel[3:1]`, an even location is bits 7:0 and an odd one bits 15:8; a read returns the byte zero-extended, and a write takes `wr_data[7:0]` into that half only.
- R5: Size code 2 is a bit access: register = `sel[6:4]`, bit = `sel[3:0]`; a read returns the bit in data bit 0 with zeros above, and a write stores `wr_data[0]` into that bit only.
- R6: Size code 0 is a word access to register `sel[3:1]`; an odd `sel[0]` accesses the same word as the even location, and `align_err` is high in that cycle (for the write port only while `wr_en` is high).
- R7: Register 7 reads and writes the user stack pointer while `sys_mode` is 0 and the supervisor stack pointer while it is 1.
- R8: During a push cycle, `stk_addr` is the live pointer minus 2 and the pointer takes that value at the edge; during a pop cycle, `stk_addr` is the live pointer and the pointer rises by 2 at the edge.
- R9: A push or pop leaves the stack pointer of the other mode unchanged.
- R10: A read of a register written in the same cycle returns the value before the write; the new value is visible from the next cycle.
- R11: With push and pop both high the push is performed; a stack strobe beats a write-port write to the live stack pointer, which is dropped.
- R12: Size code 3 is void: a write with it changes nothing and a read with it returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Bank of registers 0–3 |
| sys_mode | input | 1 | 0 selects user stack pointer, 1 supervisor |
| wr_en | input | 1 | Write port enable |
| wr_size | input | 2 | Write size code (0 word, 1 byte, 2 bit, 3 void) |
| wr_sel | input | 7 | Write location (byte location or bit address) |
| wr_data | input | 16 | Write data |
| ra_size | input | 2 | Read port A size code |
| ra_sel | input | 7 | Read port A location |
| ra_data | output | 16 | Read port A data |
| rb_size | input | 2 | Read port B size code |
| rb_sel | input | 7 | Read port B location |
| rb_data | output | 16 | Read port B data |
| push | input | 1 | Pre-decrement live stack pointer by 2 |
| pop | input | 1 | Post-increment live stack pointer by 2 |
| stk_addr | output | 16 | Memory address for the current stack access |
| align_err | output | 1 | Word access at an odd location on any active port |

## Verification
The same register is reached through word, byte and bit views in turn. This shows that a narrow write leaves the other bits untouched and that a narrow read extracts and zero-extends the right field. One value is written under one bank and read back under another. This tells banked registers apart from shared ones, and the same pattern on register 7 with the mode flipped tells the two stack pointers apart. Push and pop runs, taken from reset and from a rewritten pointer, show the pre-decrement and post-increment order and the protection of the other pointer. Same-cycle collisions of write, read, push and pop then settle the old-value read and the priority rules.

// File: rtl/brf_pkg.sv
package brf_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ACC_WORD = 2'd0,
    ACC_BYTE = 2'd1,
    ACC_BIT  = 2'd2,
    ACC_VOID = 2'd3
  } acc_e;

  // New word after a sized write lands on an old one.
  function automatic logic [WORD_W-1:0] merge_write(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] din,
    input acc_e              sz,
    input logic              hi,
    input logic [3:0]        bidx
  );
    logic [WORD_W-1:0] r;
    r = old_w;
    case (sz)
      ACC_WORD: r = din;
      ACC_BYTE: if (hi) r[15:8] = din[7:0];
                else    r[7:0]  = din[7:0];
      ACC_BIT:  r[bidx] = din[0];
      default:  r = old_w;
    endcase
    return r;
  endfunction

  // Sized view of a stored word, zero-extended.
  function automatic logic [WORD_W-1:0] pick_read(
    input logic [WORD_W-1:0] w,
    input acc_e              sz,
    input logic              hi,
    input logic [3:0]        bidx
  );
    logic [WORD_W-1:0] r;
    case (sz)
      ACC_WORD: r = w;
      ACC_BYTE: r = {8'h00, (hi ? w[15:8] : w[7:0])};
      ACC_BIT:  r = {15'd0, w[bidx]};
      default:  r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] sp_down(input logic [WORD_W-1:0] sp);
    return sp - 16'd2;
  endfunction

  function automatic logic [WORD_W-1:0] sp_up(input logic [WORD_W-1:0] sp);
    return sp + 16'd2;
  endfunction

endpackage

// File: rtl/rf_slot_map.sv
module rf_slot_map
  import brf_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int NBANKED = 4,
  parameter int NBANK   = 4,
  parameter int NSLOT   = 21,
  parameter int SLOT_W  = 5,
  parameter int BANK_W  = 2,
  parameter int SEL_W   = 7
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  acc_e              size_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              mode_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              hi_o,
  output logic [3:0]        bidx_o,
  output logic              misalign_o
);
  localparam int REG_W = $clog2(NREG);

  logic [REG_W-1:0] reg_idx;

  always_comb begin
    reg_idx = (size_i == ACC_BIT) ? sel_i[SEL_W-1:4] : sel_i[REG_W:1];
    if (reg_idx < REG_W'(NBANKED))
      slot_o = SLOT_W'(bank_i) * SLOT_W'(NBANKED) + SLOT_W'(reg_idx);
    else if (reg_idx == REG_W'(NREG-1))
      slot_o = mode_i ? SLOT_W'(NSLOT-1) : SLOT_W'(NSLOT-2);
    else
      slot_o = SLOT_W'(NBANK*NBANKED) + SLOT_W'(reg_idx) - SLOT_W'(NBANKED);
  end

  assign hi_o       = sel_i[0];
  assign bidx_o     = sel_i[3:0];
  assign misalign_o = (size_i == ACC_WORD) && sel_i[0];

endmodule

// File: rtl/rf_read_lane.sv
module rf_read_lane
  import brf_pkg::*;
#(
  parameter int NSLOT  = 21,
  parameter int SLOT_W = 5
) (
  input  logic [NSLOT-1:0][WORD_W-1:0] words_i,
  input  logic [SLOT_W-1:0]            slot_i,
  input  acc_e                         size_i,
  input  logic                         hi_i,
  input  logic [3:0]                   bidx_i,
  output logic [WORD_W-1:0]            data_o
);
  assign data_o = pick_read(words_i[slot_i], size_i, hi_i, bidx_i);
endmodule

// File: rtl/rf_store.sv
module rf_store
  import brf_pkg::*;
#(
  parameter int               NSLOT  = 21,
  parameter int               SLOT_W = 5,
  parameter logic [WORD_W-1:0] SP_RST = 16'h0100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SLOT_W-1:0]            wr_slot,
  input  acc_e                         wr_size,
  input  logic                         wr_hi,
  input  logic [3:0]                   wr_bidx,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic                         sys_mode,
  input  logic                         push,
  input  logic                         pop,
  output logic [NSLOT-1:0][WORD_W-1:0] words_o,
  output logic [WORD_W-1:0]            stk_addr
);
  localparam logic [SLOT_W-1:0] USP_SLOT = SLOT_W'(NSLOT-2);
  localparam logic [SLOT_W-1:0] SSP_SLOT = SLOT_W'(NSLOT-1);

  logic [NSLOT-1:0][WORD_W-1:0] mem;
  logic [SLOT_W-1:0] sp_slot;
  logic [WORD_W-1:0] sp_now, sp_next, usp, ssp;
  logic stk_op, push_ev, pop_ev, wr_blocked;

  assign sp_slot    = sys_mode ? SSP_SLOT : USP_SLOT;
  assign sp_now     = mem[sp_slot];
  assign push_ev    = push;
  assign pop_ev     = pop && !push;
  assign stk_op     = push_ev || pop_ev;
  assign sp_next    = push_ev ? sp_down(sp_now) : sp_up(sp_now);
  assign stk_addr   = push_ev ? sp_down(sp_now) : sp_now;
  assign wr_blocked = wr_en && stk_op && (wr_slot == sp_slot);
  assign usp        = mem[USP_SLOT];
  assign ssp        = mem[SSP_SLOT];
  assign words_o    = mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++)
        mem[i] <= (i >= NSLOT-2) ? SP_RST : '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (stk_op && (sp_slot == SLOT_W'(i)))
          mem[i] <= sp_next;
        else if (wr_en && (wr_slot == SLOT_W'(i)))
          mem[i] <= merge_write(mem[i], wr_data, wr_size, wr_hi, wr_bidx);
      end
    end
  end

  // R8: push lowers the live user pointer by two
  a_r8_push_lowers_usp: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev && !sys_mode) |=> (usp == $past(usp) - 16'd2));

  // R8: pop raises the live supervisor pointer by two
  a_r8_pop_raises_ssp: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && sys_mode) |=> (ssp == $past(ssp) + 16'd2));

  // R9: user-mode stack activity leaves the supervisor pointer alone
  a_r9_ssp_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_op && !sys_mode && !(wr_en && wr_slot == SSP_SLOT)) |=> $stable(ssp));

  // R4: a low-byte write keeps the high half
  a_r4_byte_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == ACC_BYTE && !wr_hi && !wr_blocked)
      |=> (mem[$past(wr_slot)][15:8] == $past(mem[wr_slot][15:8])));

  // R11: a write colliding with a stack step is dropped
  a_r11_stack_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> (mem[$past(sp_slot)] == $past(sp_next)));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int          NREG    = 8,
  parameter int          NBANKED = 4,
  parameter int          NBANK   = 4,
  parameter logic [15:0] SP_RST  = 16'h0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bank_sel,
  input  logic        sys_mode,
  input  logic        wr_en,
  input  logic [1:0]  wr_size,
  input  logic [6:0]  wr_sel,
  input  logic [15:0] wr_data,
  input  logic [1:0]  ra_size,
  input  logic [6:0]  ra_sel,
  output logic [15:0] ra_data,
  input  logic [1:0]  rb_size,
  input  logic [6:0]  rb_sel,
  output logic [15:0] rb_data,
  input  logic        push,
  input  logic        pop,
  output logic [15:0] stk_addr,
  output logic        align_err
);
  localparam int REG_W   = $clog2(NREG);
  localparam int BANK_W  = $clog2(NBANK);
  localparam int SEL_W   = REG_W + 4;
  localparam int NSHARED = NREG - 1 - NBANKED;
  localparam int NSLOT   = NBANK*NBANKED + NSHARED + 2;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int NPORT   = 3;  // 0 write, 1 read A, 2 read B

  acc_e              sz_q   [NPORT];
  logic [SEL_W-1:0]  sel_q  [NPORT];
  logic [SLOT_W-1:0] slot_q [NPORT];
  logic [3:0]        bidx_q [NPORT];
  logic [NPORT-1:0]  hi_q, mis_q;
  logic [15:0]       rd_q   [2];
  logic [NSLOT-1:0][WORD_W-1:0] words;

  assign sz_q[0]  = acc_e'(wr_size);
  assign sz_q[1]  = acc_e'(ra_size);
  assign sz_q[2]  = acc_e'(rb_size);
  assign sel_q[0] = wr_sel;
  assign sel_q[1] = ra_sel;
  assign sel_q[2] = rb_sel;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rf_slot_map #(
      .NREG(NREG), .NBANKED(NBANKED), .NBANK(NBANK), .NSLOT(NSLOT),
      .SLOT_W(SLOT_W), .BANK_W(BANK_W), .SEL_W(SEL_W)
    ) u_map (
      .sel_i(sel_q[p]), .size_i(sz_q[p]), .bank_i(bank_sel), .mode_i(sys_mode),
      .slot_o(slot_q[p]), .hi_o(hi_q[p]), .bidx_o(bidx_q[p]), .misalign_o(mis_q[p])
    );
  end

  assign align_err = (mis_q[0] && wr_en) || mis_q[1] || mis_q[2];

  rf_store #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .SP_RST(SP_RST)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(slot_q[0]),
    .wr_size(sz_q[0]), .wr_hi(hi_q[0]), .wr_bidx(bidx_q[0]), .wr_data(wr_data),
    .sys_mode(sys_mode), .push(push), .pop(pop),
    .words_o(words), .stk_addr(stk_addr)
  );

  for (genvar r = 0; r < 2; r++) begin : g_rd
    rf_read_lane #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_lane (
      .words_i(words), .slot_i(slot_q[r+1]), .size_i(sz_q[r+1]),
      .hi_i(hi_q[r+1]), .bidx_i(bidx_q[r+1]), .data_o(rd_q[r])
    );
  end

  assign ra_data = rd_q[0];
  assign rb_data = rd_q[1];

  // R6: an odd word read on port A raises the alignment flag
  a_r6_odd_word_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_size == 2'd0 && ra_sel[0]) |-> align_err);

endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bank_sel = '0;
  logic        sys_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = '0;
  logic [6:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  ra_size = '0, rb_size = '0;
  logic [6:0]  ra_sel = '0, rb_sel = '0;
  logic [15:0] ra_data, rb_data, stk_addr;
  logic        push = 1'b0, pop = 1'b0;
  logic        align_err;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;

  typedef struct {
    string       tag;
    int          kind;   // 0 ra_data, 1 rb_data, 2 align_err, 3 stk_addr
    logic [15:0] exp;
  } item_t;
  item_t sb[$];

  localparam logic [1:0] SW = 2'd0, SB = 2'd1, SBIT = 2'd2, SV = 2'd3;

  always #2.5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .sys_mode(sys_mode),
    .wr_en(wr_en), .wr_size(wr_size), .wr_sel(wr_sel), .wr_data(wr_data),
    .ra_size(ra_size), .ra_sel(ra_sel), .ra_data(ra_data),
    .rb_size(rb_size), .rb_sel(rb_sel), .rb_data(rb_data),
    .push(push), .pop(pop), .stk_addr(stk_addr), .align_err(align_err)
  );

  // Monitor: compares queued expectations 1 ns after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = ra_data;
          1: act = rb_data;
          2: act = {15'd0, align_err};
          default: act = stk_addr;
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [15:0] exp, input string tag);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
    wr_en = 1'b0; push = 1'b0; pop = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [6:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_size = sz; wr_sel = sel; wr_data = d;
  endtask

  task automatic rd_a(input logic [1:0] sz, input logic [6:0] sel, input logic [15:0] e, input string tag);
    ra_size = sz; ra_sel = sel; expect_item(0, e, tag);
  endtask

  task automatic rd_b(input logic [1:0] sz, input logic [6:0] sel, input logic [15:0] e, input string tag);
    rb_size = sz; rb_sel = sel; expect_item(1, e, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    step(); rd_a(SW, 7'd14, 16'h0100, "R1 usp reset"); rd_b(SW, 7'd0, 16'h0000, "R1 r0 reset");
    expect_item(3, 16'h0100, "R1 idle stk_addr"); expect_item(2, 16'h0000, "R1 no align_err");
    step(); sys_mode = 1'b1; rd_a(SW, 7'd14, 16'h0100, "R1 ssp reset");
    // R8: first push from reset
    step(); sys_mode = 1'b0; push = 1'b1; expect_item(3, 16'h00FE, "R8 first push addr");
    step(); rd_a(SW, 7'd14, 16'h00FE, "R8 sp after push"); pop = 1'b1;
    expect_item(3, 16'h00FE, "R8 pop addr");
    step(); rd_a(SW, 7'd14, 16'h0100, "R8 sp after pop");
    step(); sys_mode = 1'b1; rd_a(SW, 7'd14, 16'h0100, "R9 ssp kept");
    // R2 / R10: banks and same-cycle read
    step(); sys_mode = 1'b0; bank_sel = 2'd0; wr(SW, 7'd4, 16'h1234);
    rd_b(SW, 7'd4, 16'h0000, "R10 old value on collision");
    step(); rd_a(SW, 7'd4, 16'h1234, "R10 new value next cycle");
    step(); bank_sel = 2'd1; rd_a(SW, 7'd4, 16'h0000, "R2 bank1 copy separate");
    wr(SW, 7'd4, 16'hABCD);
    step(); bank_sel = 2'd0; rd_a(SW, 7'd4, 16'h1234, "R2 bank0 intact");
    step(); bank_sel = 2'd1; rd_a(SW, 7'd4, 16'hABCD, "R2 bank1 value");
    // R3: shared register
    step(); bank_sel = 2'd2; wr(SW, 7'd8, 16'h5555);
    step(); bank_sel = 2'd3; rd_a(SW, 7'd8, 16'h5555, "R3 shared across banks");
    wr(SB, 7'd9, 16'h00AA);
    // R4: byte view
    step(); rd_a(SW, 7'd8, 16'hAA55, "R4 high byte write"); rd_b(SB, 7'd8, 16'h0055, "R4 low byte read");
    step(); rd_a(SB, 7'd9, 16'h00AA, "R4 high byte read"); wr(SBIT, 7'h40, 16'h0000);
    // R5: bit view
    step(); rd_a(SW, 7'd8, 16'hAA54, "R5 clear bit0"); wr(SBIT, 7'h4F, 16'h0000);
    step(); rd_a(SW, 7'd8, 16'h2A54, "R5 clear bit15"); rd_b(SBIT, 7'h4D, 16'h0001, "R5 bit13 read");
    // R6: odd word access
    step(); rd_a(SW, 7'd9, 16'h2A54, "R6 odd word read"); rb_size = SB; rb_sel = 7'd8;
    expect_item(2, 16'h0001, "R6 read align_err");
    step(); ra_size = SB; ra_sel = 7'd8; wr(SW, 7'd11, 16'h7777);
    expect_item(2, 16'h0001, "R6 write align_err");
    step(); rd_a(SW, 7'd10, 16'h7777, "R6 odd word write"); rd_b(SB, 7'd11, 16'h0077, "R6 odd byte read");
    expect_item(2, 16'h0000, "R6 no align_err");
    // R7: stack pointer alias
    step(); sys_mode = 1'b0; wr(SW, 7'd14, 16'h0200);
    step(); sys_mode = 1'b1; rd_a(SW, 7'd14, 16'h0100, "R7 ssp separate"); wr(SW, 7'd14, 16'h0300);
    step(); rd_a(SW, 7'd14, 16'h0300, "R7 ssp written");
    step(); sys_mode = 1'b0; rd_a(SW, 7'd14, 16'h0200, "R7 usp kept"); push = 1'b1;
    expect_item(3, 16'h01FE, "R8 push addr");
    step(); sys_mode = 1'b1; rd_a(SW, 7'd14, 16'h0300, "R9 ssp after user push");
    // R11: priorities
    step(); sys_mode = 1'b0; rd_a(SW, 7'd14, 16'h01FE, "R8 usp after push");
    push = 1'b1; pop = 1'b1; wr(SW, 7'd14, 16'h4444);
    expect_item(3, 16'h01FC, "R11 push beats pop");
    step(); rd_a(SW, 7'd14, 16'h01FC, "R11 write dropped");
    // R12: void size
    wr(SV, 7'd10, 16'hFFFF); rd_b(SV, 7'd10, 16'h0000, "R12 void read");
    step(); rd_a(SW, 7'd10, 16'h7777, "R12 void write ignored");
    step(); step();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule